// File: doc/BRIEF.md
# Ethernet DMA Interrupt Status and Summary Register

This block holds the interrupt status of an Ethernet DMA engine behind a small register port. Single-cycle event pulses from the DMA engine set sticky status bits. Software clears a bit by writing a one to its position. A separate enable register selects which events take part in two sticky summary bits. The normal summary gathers completion-type events and the abnormal summary gathers error and stall events. A single interrupt line is driven from the two summary bits, each gated by its own enable bit.

The status word also reports, read-only, the current state code of the receive DMA state machine, which lives outside this block. That field never causes an interrupt. Reads return data combinationally for the presented address. Writes take effect on the next rising clock edge.

Top module: `dma_irq_status_reg`

## Requirements
- R1: After reset, every status bit, both summary bits and every enable bit read 0, and `irq_o` is low.
- R2: A pulse on `ev_pulse_i[i]` for an implemented event position (0 to 10, 13, 14) sets status bit i at the next rising edge. The bit stays set until it is cleared by a write.
- R3: A write to the status address (offset 0x0) with a 1 in bit i (i in 0..14) clears status bit i, and a 0 in that position leaves the bit unchanged. If a pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R4: The normal summary (status bit 16) is set one edge after any of status bits 0, 2, 6 or 14 reads 1 while the matching enable bit is 1.
- R5: The abnormal summary (status bit 15) is set one edge after any of status bits 1, 3, 4, 5, 7, 8, 9, 10 or 13 reads 1 while the matching enable bit is 1.
- R6: A status bit whose enable bit is 0 leaves both summary bits unchanged.
- R7: Each summary bit stays set until a 1 is written to its own position at the status address, and the other summary bit is not affected by that write. If an enabled member of its group is still set at the time of the write, the summary bit stays set.
- R8: Status bits 19:17 always show the value of `rx_state_i` (0 stopped, 1 fetching a descriptor, 2 reserved, 3 waiting for a packet, 4 suspended, 5 closing a descriptor, 6 writing a timestamp, 7 moving data to host memory). Writes to these bits are ignored, and the field never drives `irq_o`.
- R9: `irq_o` is high exactly when (status bit 16 AND enable bit 16) OR (status bit 15 AND enable bit 15).
- R10: The enable register at offset 0x4 is read/write on bits 0..10 and 13..16, and it resets to 0.
- R11: The following read as 0 and ignore writes: status bits 11, 12 and 31:20, enable bits 11, 12 and 31:17, and every other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Byte address of the register access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| ev_pulse_i | input | 15 | Event pulses, one per status bit position 0..14 |
| rx_state_i | input | 3 | Current receive DMA state code |
| irq_o | output | 1 | Interrupt request |

## Verification
A status bit is due one rising edge after its pulse. A summary bit is due one edge after that, because it is built from the registered status bits. `irq_o` follows the summary bits in the same cycle, and read data follows the address combinationally. The bench therefore changes its inputs on falling edges, lets the required number of rising edges pass, and samples shortly after a falling edge. It sweeps every event position with its enable set and cleared, and every receive state code.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int EV_W    = 15;
  localparam int AIS_BIT = 15;
  localparam int NIS_BIT = 16;
  localparam int RXS_LSB = 17;
  localparam int RXS_W   = 3;
  localparam int EN_W    = NIS_BIT + 1;

  // group membership of the event positions
  localparam logic [EV_W-1:0] NORMAL_MASK = 15'h4045; // 0,2,6,14
  localparam logic [EV_W-1:0] ABN_MASK    = 15'h27BA; // 1,3,4,5,7,8,9,10,13
  localparam logic [EV_W-1:0] EV_IMPL     = NORMAL_MASK | ABN_MASK;
  localparam logic [EN_W-1:0] EN_IMPL     = {2'b11, EV_IMPL};

  typedef enum logic [RXS_W-1:0] {
    RXS_STOPPED   = 3'd0,
    RXS_FETCH     = 3'd1,
    RXS_RSVD      = 3'd2,
    RXS_WAIT_PKT  = 3'd3,
    RXS_SUSPENDED = 3'd4,
    RXS_CLOSE     = 3'd5,
    RXS_TSTAMP    = 3'd6,
    RXS_XFER      = 3'd7
  } rx_state_e;
endpackage

// File: rtl/dma_irq_sticky_bank.sv
module dma_irq_sticky_bank #(
  parameter int               W    = 15,
  parameter logic [W-1:0]     IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic q_q, q_d;
      // set has priority so a pulse is never lost
      always_comb begin
        q_d = q_q;
        if (clr_i[i]) q_d = 1'b0;
        if (set_i[i]) q_d = 1'b1;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
      end
      assign q_o[i] = q_q;
    end else begin : g_rsvd
      logic unused_b;
      assign unused_b = set_i[i] ^ clr_i[i];
      assign q_o[i]   = 1'b0;
    end
  end
endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary
  import dma_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] stat_i,
  input  logic [EV_W-1:0] en_i,
  input  logic            clr_nis_i,
  input  logic            clr_ais_i,
  output logic            nis_o,
  output logic            ais_o
);
  logic nis_q, ais_q, nis_d, ais_d;
  logic nis_hit, ais_hit;

  always_comb begin
    nis_hit = |(stat_i & en_i & NORMAL_MASK);
    ais_hit = |(stat_i & en_i & ABN_MASK);
    nis_d   = nis_q;
    ais_d   = ais_q;
    if (clr_nis_i) nis_d = 1'b0;
    if (clr_ais_i) ais_d = 1'b0;
    if (nis_hit)   nis_d = 1'b1;
    if (ais_hit)   ais_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nis_q <= 1'b0;
      ais_q <= 1'b0;
    end else begin
      nis_q <= nis_d;
      ais_q <= ais_d;
    end
  end

  assign nis_o = nis_q;
  assign ais_o = ais_q;
endmodule

// File: rtl/dma_irq_en_reg.sv
module dma_irq_en_reg #(
  parameter int           W    = 17,
  parameter logic [W-1:0] IMPL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      logic q_q, q_d;
      always_comb begin
        q_d = q_q;
        if (we_i) q_d = wdata_i[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= 1'b0;
        else        q_q <= q_d;
      end
      assign q_o[i] = q_q;
    end else begin : g_rsvd
      logic unused_b;
      assign unused_b = wdata_i[i];
      assign q_o[i]   = 1'b0;
    end
  end
endmodule

// File: rtl/dma_irq_status_reg.sv
module dma_irq_status_reg
  import dma_irq_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] STAT_OFFS = 4'h0,
  parameter logic [ADDR_W-1:0] EN_OFFS   = 4'h4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [EV_W-1:0]   ev_pulse_i,
  input  logic [RXS_W-1:0]  rx_state_i,
  output logic              irq_o
);
  logic              stat_we, en_we;
  logic [EV_W-1:0]   stat_clr;
  logic [EV_W-1:0]   stat_q;
  logic [EN_W-1:0]   en_q;
  logic              nis_q, ais_q;
  logic [DATA_W-1:0] stat_word, en_word;
  logic              unused_wdata;

  assign stat_we  = wr_en_i && (addr_i == STAT_OFFS);
  assign en_we    = wr_en_i && (addr_i == EN_OFFS);
  assign stat_clr = stat_we ? wdata_i[EV_W-1:0] : '0;
  assign unused_wdata = ^wdata_i[DATA_W-1:EN_W];

  dma_irq_sticky_bank #(.W(EV_W), .IMPL(EV_IMPL)) u_events (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (ev_pulse_i),
    .clr_i (stat_clr),
    .q_o   (stat_q)
  );

  dma_irq_summary u_summary (
    .clk       (clk),
    .rst_n     (rst_n),
    .stat_i    (stat_q),
    .en_i      (en_q[EV_W-1:0]),
    .clr_nis_i (stat_we && wdata_i[NIS_BIT]),
    .clr_ais_i (stat_we && wdata_i[AIS_BIT]),
    .nis_o     (nis_q),
    .ais_o     (ais_q)
  );

  dma_irq_en_reg #(.W(EN_W), .IMPL(EN_IMPL)) u_enable (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (en_we),
    .wdata_i (wdata_i[EN_W-1:0]),
    .q_o     (en_q)
  );

  always_comb begin
    stat_word                      = '0;
    stat_word[EV_W-1:0]            = stat_q;
    stat_word[AIS_BIT]             = ais_q;
    stat_word[NIS_BIT]             = nis_q;
    stat_word[RXS_LSB +: RXS_W]    = rx_state_i;
    en_word                        = '0;
    en_word[EN_W-1:0]              = en_q;
  end

  always_comb begin
    if (addr_i == STAT_OFFS)    rdata_o = stat_word;
    else if (addr_i == EN_OFFS) rdata_o = en_word;
    else                        rdata_o = '0;
  end

  assign irq_o = (nis_q & en_q[NIS_BIT]) | (ais_q & en_q[AIS_BIT]);
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk
  import dma_irq_pkg::*;
#(
  parameter int                ADDR_W    = 4,
  parameter logic [ADDR_W-1:0] STAT_OFFS = 4'h0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [EV_W-1:0]   ev_pulse_i,
  input logic [RXS_W-1:0]  rx_state_i,
  input logic              irq_o,
  input logic [EV_W-1:0]   stat_q,
  input logic [EN_W-1:0]   en_q,
  input logic              nis_q,
  input logic              ais_q
);
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_pulse_i & EV_IMPL)) |=>
      ((stat_q & $past(ev_pulse_i & EV_IMPL)) == $past(ev_pulse_i & EV_IMPL)));

  assert_write0_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == STAT_OFFS && wdata_i[EV_W-1:0] == '0 && ev_pulse_i == '0)
      |=> $stable(stat_q));

  assert_nis_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & en_q[EV_W-1:0] & NORMAL_MASK)) |=> nis_q);

  assert_ais_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(stat_q & en_q[EV_W-1:0] & ABN_MASK)) |=> ais_q);

  assert_nis_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!nis_q && !(|(stat_q & en_q[EV_W-1:0] & NORMAL_MASK))) |=> !nis_q);

  assert_ais_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ais_q && !(|(stat_q & en_q[EV_W-1:0] & ABN_MASK))) |=> !ais_q);

  assert_rx_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_i == STAT_OFFS) |-> (rdata_o[RXS_LSB +: RXS_W] == rx_state_i));

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (nis_q || ais_q));

  assert_rsvd_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata_o[DATA_W-1:RXS_LSB+RXS_W] == '0) && (rdata_o[12:11] == 2'b00));
endmodule

bind dma_irq_status_reg dma_irq_status_chk #(
  .ADDR_W    (ADDR_W),
  .STAT_OFFS (STAT_OFFS)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en_i    (wr_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .ev_pulse_i (ev_pulse_i),
  .rx_state_i (rx_state_i),
  .irq_o      (irq_o),
  .stat_q     (stat_q),
  .en_q       (en_q),
  .nis_q      (nis_q),
  .ais_q      (ais_q)
);

// File: tb/dma_irq_status_reg_tb.sv
`timescale 1ns/1ps
module dma_irq_status_reg_tb_top;
  localparam logic [3:0] A_STAT = 4'h0;
  localparam logic [3:0] A_EN   = 4'h4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = 4'h0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [14:0] ev_pulse_i = '0;
  logic [2:0]  rx_state_i = 3'd0;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #5 clk = ~clk;

  dma_irq_status_reg dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ev_pulse_i(ev_pulse_i),
    .rx_state_i(rx_state_i), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic pulse(input logic [14:0] v);
    @(negedge clk);
    ev_pulse_i = v;
    @(negedge clk);
    ev_pulse_i = '0;
  endtask

  function automatic bit is_norm(input int i);
    return (i == 0) || (i == 2) || (i == 6) || (i == 14);
  endfunction
  function automatic bit is_abn(input int i);
    return (i == 1) || (i == 3) || (i == 4) || (i == 5) || (i == 7) ||
           (i == 8) || (i == 9) || (i == 10) || (i == 13);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [31:0] exp;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(A_STAT, r); check("R1 status after reset", r, 32'h0);
    rd(A_EN, r);   check("R1 enable after reset", r, 32'h0);
    check("R1 irq after reset", {31'b0, irq_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10/R11 enable read/write mask, unused address
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, r); check("R10 R11 enable write mask", r, 32'h0001_E7FF);
    wr(A_EN, 32'h0);
    rd(A_EN, r); check("R10 enable write zero", r, 32'h0);
    rd(4'h8, r); check("R11 unused address", r, 32'h0);

    // R2 R4 R5 R6 R9 R3 R7 sweep over every event position, enabled and not
    for (int i = 0; i < 15; i++) begin
      for (int en = 0; en < 2; en++) begin
        wr(A_EN, (en != 0) ? ((32'h1 << i) | 32'h0001_8000) : 32'h0001_8000);
        pulse(15'h1 << i);
        @(negedge clk);
        exp = 32'h0;
        if (is_norm(i) || is_abn(i)) exp[i] = 1'b1;
        if (en != 0 && is_norm(i)) exp[16] = 1'b1;
        if (en != 0 && is_abn(i))  exp[15] = 1'b1;
        rd(A_STAT, r);
        check($sformatf("R2 R4 R5 R6 R11 status bit %0d en %0d", i, en), r, exp);
        check($sformatf("R9 irq bit %0d en %0d", i, en), {31'b0, irq_o},
              {31'b0, exp[16] | exp[15]});
        wr(A_STAT, 32'h0000_7FFF);
        wr(A_STAT, 32'h0001_8000);
        rd(A_STAT, r);
        check($sformatf("R3 R7 cleared bit %0d en %0d", i, en), r, 32'h0);
      end
    end

    // R3 write zero keeps a bit
    pulse(15'h0008);
    wr(A_STAT, 32'h0);
    rd(A_STAT, r); check("R3 write zero no effect", r[14:0], 32'h8);
    // R3 set and clear in the same cycle: set wins
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = A_STAT; wdata_i = 32'h0000_0028; ev_pulse_i = 15'h0020;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0; ev_pulse_i = '0;
    rd(A_STAT, r); check("R3 set wins over clear", r[14:0], 32'h20);
    wr(A_STAT, 32'h0001_FFFF);

    // R7 summary clear while member still set: stays; clears separately
    wr(A_EN, 32'h0001_8041);
    pulse(15'h0001);
    @(negedge clk);
    pulse(15'h0002); // not enabled in abnormal group: ais must stay 0
    @(negedge clk);
    wr(A_STAT, 32'h0001_0000);
    rd(A_STAT, r); check("R7 nis held while member set", r[16:15], 32'h2);
    wr(A_STAT, 32'h0000_0003);
    rd(A_STAT, r); check("R7 nis sticky after member clear", r[16:0], 32'h1_0000);
    wr(A_STAT, 32'h0000_8000);
    rd(A_STAT, r); check("R7 ais clear leaves nis", r[16:0], 32'h1_0000);
    wr(A_STAT, 32'h0001_0000);
    rd(A_STAT, r); check("R7 nis cleared", r, 32'h0);

    // R9 summary set but its enable off: no irq, then enable it
    wr(A_EN, 32'h0000_0001);
    pulse(15'h0001);
    @(negedge clk);
    rd(A_STAT, r); check("R9 nis set", r[16:0], 32'h1_0001);
    check("R9 irq off without bit16 enable", {31'b0, irq_o}, 32'h0);
    wr(A_EN, 32'h0001_0001);
    check("R9 irq on with bit16 enable", {31'b0, irq_o}, 32'h1);
    wr(A_STAT, 32'h0000_0001);
    wr(A_STAT, 32'h0001_0000);
    check("R9 irq off after clear", {31'b0, irq_o}, 32'h0);

    // R8 receive state field sweep, never an interrupt, not writable
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      rx_state_i = 3'(s);
      rd(A_STAT, r);
      check($sformatf("R8 rx state %0d", s), r, 32'(s) << 17);
      check($sformatf("R8 rx state %0d no irq", s), {31'b0, irq_o}, 32'h0);
    end
    rx_state_i = 3'd2;
    wr(A_STAT, 32'h000E_0000);
    rd(A_STAT, r); check("R8 rx field write ignored", r, 32'h0004_0000);
    wr(A_STAT, 32'hFFF0_1800);
    rd(A_STAT, r); check("R11 reserved status write ignored", r, 32'h0004_0000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule